// File: doc/BRIEF.md
# Joystick Axis Timing Measurement Unit

This unit finds the position of up to four analog joystick axes by measuring time. Each axis has an external one-shot circuit whose output stays high for a time that depends on the position of the potentiometer. A host writes to the unit to start a measurement. Each enabled axis then has its counter cleared, and the counter advances at a prescaled rate for as long as that axis's comparator input stays high. When every enabled axis has stopped, a ready flag rises and an optional interrupt is raised.

The host uses a small byte-wide register bus. An axis configuration register holds the per-axis enables, a read-select field, the continuous mode bit and the read-only ready flag. The selected axis count is read as two bytes. A hardware configuration register holds the interrupt enable, the count rate and a legacy address enable. In continuous mode the unit starts a new measurement by itself a fixed number of prescaled ticks after each one completes. Each of these automatic measurements raises the flag, and the interrupt if it is enabled, again.

Top module: `joy_axis_timer`

## Requirements
- R1: After reset, every register reads zero, the ready flag and `irq` are low, and all axis counts are zero.
- R2: A write to offset 2 starts a measurement. Each enabled axis count clears and then advances once per prescaled tick while its comparator input is high. The count stops when the input goes low, so an input held high for W clock edges after the start edge gives a count of floor(W/D), where D is the divisor.
- R3: Bit k (k = 0..3) of the axis configuration register (offset 1) enables axis k+1. A measurement leaves the count of a disabled axis unchanged.
- R4: Bits 5:4 of offset 1 select the axis to read, with 0 selecting axis 1 up to 3 selecting axis 4. Offset 2 returns bits 7:0 of the selected count and offset 3 returns bits 15:8.
- R5: Bits 2:1 of the hardware configuration register (offset 4) set the divisor D. The value 0 gives 1, 1 gives 2, 2 gives 20 and 3 gives 200.
- R6: A count that reaches 0xFFFF holds there and stops, and does not wrap.
- R7: Bit 7 of offset 1 reads 1 once every enabled axis has stopped and returns to 0 when the next measurement starts. Writes to that bit have no effect.
- R8: `irq` is high exactly when the ready flag is 1 and bit 0 of offset 4 is 1.
- R9: A write to offset 0 starts a measurement only while at least one axis is enabled and bit 0 of offset 4 is set. Otherwise the write has no effect.
- R10: With bit 6 of offset 1 set, a new measurement starts by itself REARM_GAP ticks after the ready flag rises. Clearing the bit stops these automatic starts.
- R11: Bits 7:4 of offset 4 always read zero. Bit 3 is stored and drives `legacy_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| axis_cmp | input | 4 | Comparator inputs, high while an axis one-shot runs |
| irq | output | 1 | Ready interrupt |
| legacy_en | output | 1 | Legacy address enable |

## Verification
Random enable masks and random per-axis pulse widths run at the full and divided rates. This separates the per-axis enable and hold behaviour from the count arithmetic, and the read select from the two byte lanes. Directed cases use the 1/2 and 1/200 rates to pin the divisor mapping. A pulse longer than 65535 cycles shows saturation rather than wrap. Comparator inputs held low with continuous mode set make the ready flag cycle with no host writes, and the cycling stops once the mode bit is cleared. Writes to offset 0 with the interrupt disabled and then enabled show when that trigger is gated.

// File: rtl/joy_pkg.sv
package joy_pkg;

   typedef enum logic [1:0] {
      RATE_FULL  = 2'd0,
      RATE_HALF  = 2'd1,
      RATE_TWENT = 2'd2,
      RATE_SLOW  = 2'd3
   } joy_rate_e;

   localparam logic [2:0] OFS_LEGACY = 3'd0;
   localparam logic [2:0] OFS_AXCFG  = 3'd1;
   localparam logic [2:0] OFS_VAL_LO = 3'd2;
   localparam logic [2:0] OFS_VAL_HI = 3'd3;
   localparam logic [2:0] OFS_HWCFG  = 3'd4;

   localparam int VALUE_BYTES_W = 16;

endpackage

// File: rtl/joy_prescaler.sv
module joy_prescaler
   import joy_pkg::*;
#(
   parameter int DIV_HALF  = 2,
   parameter int DIV_TWENT = 20,
   parameter int DIV_SLOW  = 200
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      clear,
   input  joy_rate_e rate,
   output logic      tick
);
   localparam int PW = $clog2(DIV_SLOW);

   generate
      if (DIV_HALF < 2 || DIV_TWENT < DIV_HALF || DIV_SLOW < DIV_TWENT) begin : g_bad_div
         $error("joy_prescaler: divisors must rise from 2");
      end
   endgenerate

   logic [PW-1:0] pc_q;
   logic [PW-1:0] lim;

   always_comb begin
      unique case (rate)
         RATE_FULL:  lim = '0;
         RATE_HALF:  lim = PW'(DIV_HALF - 1);
         RATE_TWENT: lim = PW'(DIV_TWENT - 1);
         default:    lim = PW'(DIV_SLOW - 1);
      endcase
   end

   assign tick = (pc_q >= lim);

   always_ff @(posedge clk) begin
      if (!rst_n || clear || tick) pc_q <= '0;
      else                         pc_q <= pc_q + 1'b1;
   end

   AST_FULL_RATE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (rate == RATE_FULL) |-> tick); // R5

endmodule

// File: rtl/joy_axis_counter.sv
module joy_axis_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             enable,
   input  logic             tick,
   input  logic             cmp,
   output logic             running,
   output logic [CNT_W-1:0] value
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running <= 1'b0;
         value   <= '0;
      end else if (start) begin
         running <= enable;
         if (enable) value <= '0;
      end else if (running) begin
         if (!cmp)                  running <= 1'b0;
         else if (tick) begin
            if (value == CNT_MAX)   running <= 1'b0;
            else                    value   <= value + 1'b1;
         end
      end
   end

   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (start && enable) |=> (value == '0)); // R2
   AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !enable) |=> $stable(value)); // R3
   AST_CMP_LOW_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !cmp && !start) |=> !running); // R2
   AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (running && value == CNT_MAX && !start) |=> (value == CNT_MAX)); // R6

endmodule

// File: rtl/joy_axis_timer.sv
module joy_axis_timer
   import joy_pkg::*;
#(
   parameter int AXES      = 4,
   parameter int CNT_W     = 16,
   parameter int REARM_GAP = 8,
   parameter int DIV_HALF  = 2,
   parameter int DIV_TWENT = 20,
   parameter int DIV_SLOW  = 200
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [2:0]      reg_addr,
   input  logic            reg_wr,
   input  logic [7:0]      reg_wdata,
   output logic [7:0]      reg_rdata,
   input  logic [AXES-1:0] axis_cmp,
   output logic            irq,
   output logic            legacy_en
);
   localparam int GAP_W = $clog2(REARM_GAP + 1);

   generate
      if (AXES < 1 || AXES > 4) begin : g_bad_axes
         $error("joy_axis_timer: AXES must be 1..4");
      end
      if (CNT_W < 2 || CNT_W > VALUE_BYTES_W) begin : g_bad_cnt
         $error("joy_axis_timer: CNT_W must be 2..16");
      end
      if (REARM_GAP < 1) begin : g_bad_gap
         $error("joy_axis_timer: REARM_GAP must be at least 1");
      end
   endgenerate

   logic [3:0]       en_q;
   logic [1:0]       sel_q;
   logic             latch_q;
   logic             irq_en_q;
   joy_rate_e        rate_q;
   logic             legacy_q;
   logic             busy_q;
   logic             ready_q;
   logic [GAP_W-1:0] gap_q;

   logic                       tick;
   logic [AXES-1:0]            run;
   logic [AXES-1:0][CNT_W-1:0] vals;
   logic                       wr_val, wr_leg, auto_go, start;
   logic [VALUE_BYTES_W-1:0]   sel_wide;

   assign wr_val  = reg_wr && (reg_addr == OFS_VAL_LO);
   assign wr_leg  = reg_wr && (reg_addr == OFS_LEGACY) && (|en_q[AXES-1:0]) && irq_en_q;
   assign auto_go = latch_q && ready_q && tick && (gap_q == GAP_W'(REARM_GAP - 1));
   assign start   = wr_val || wr_leg || auto_go;

   // host-writable configuration
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q     <= '0;
         sel_q    <= '0;
         latch_q  <= 1'b0;
         irq_en_q <= 1'b0;
         rate_q   <= RATE_FULL;
         legacy_q <= 1'b0;
      end else if (reg_wr) begin
         if (reg_addr == OFS_AXCFG) begin
            en_q    <= reg_wdata[3:0];
            sel_q   <= reg_wdata[5:4];
            latch_q <= reg_wdata[6];
         end else if (reg_addr == OFS_HWCFG) begin
            irq_en_q <= reg_wdata[0];
            rate_q   <= joy_rate_e'(reg_wdata[2:1]);
            legacy_q <= reg_wdata[3];
         end
      end
   end

   // measurement sequencing and continuous re-arm
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         ready_q <= 1'b0;
         gap_q   <= '0;
      end else if (start) begin
         busy_q  <= 1'b1;
         ready_q <= 1'b0;
         gap_q   <= '0;
      end else if (busy_q && (run == '0)) begin
         busy_q  <= 1'b0;
         ready_q <= 1'b1;
      end else if (!latch_q) begin
         gap_q <= '0;
      end else if (ready_q && tick) begin
         gap_q <= gap_q + 1'b1;
      end
   end

   joy_prescaler #(
      .DIV_HALF  (DIV_HALF),
      .DIV_TWENT (DIV_TWENT),
      .DIV_SLOW  (DIV_SLOW)
   ) u_prescaler (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (start),
      .rate  (rate_q),
      .tick  (tick)
   );

   generate
      for (genvar i = 0; i < AXES; i++) begin : g_axis
         joy_axis_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .start   (start),
            .enable  (en_q[i]),
            .tick    (tick),
            .cmp     (axis_cmp[i]),
            .running (run[i]),
            .value   (vals[i])
         );
      end
   endgenerate

   always_comb begin
      sel_wide = '0;
      for (int k = 0; k < AXES; k++) begin
         if (sel_q == 2'(k)) sel_wide[CNT_W-1:0] = vals[k];
      end
   end

   always_comb begin
      unique case (reg_addr)
         OFS_AXCFG:  reg_rdata = {ready_q, latch_q, sel_q, en_q};
         OFS_VAL_LO: reg_rdata = sel_wide[7:0];
         OFS_VAL_HI: reg_rdata = sel_wide[15:8];
         OFS_HWCFG:  reg_rdata = {4'b0000, legacy_q, rate_q, irq_en_q};
         default:    reg_rdata = 8'h00;
      endcase
   end

   assign irq       = ready_q & irq_en_q;
   assign legacy_en = legacy_q;

   AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      ready_q |-> (run == '0)); // R7
   AST_LEGACY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == OFS_LEGACY && !irq_en_q && !auto_go && !busy_q) |=> !busy_q); // R9

endmodule

// File: tb/joy_axis_timer_bench.sv
module joy_axis_timer_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] reg_addr = '0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic [3:0] axis_cmp = '0;
   logic       irq, legacy_en;

   int total = 0;
   int bad = 0;
   int wq[4];
   int expv[4];
   logic [7:0] d;

   always #4 clk = ~clk;

   joy_axis_timer u_joy_axis_timer (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .axis_cmp(axis_cmp),
      .irq(irq), .legacy_en(legacy_en)
   );

   function automatic int div_of(input logic [1:0] r);
      case (r)
         2'd0: return 1;
         2'd1: return 2;
         2'd2: return 20;
         default: return 200;
      endcase
   endfunction

   function automatic int exp_count(input int w, input logic [1:0] r);
      int c = w / div_of(r);
      return (c > 65535) ? 65535 : c;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] v);
      @(negedge clk);
      reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
      @(posedge clk);
      #1 reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] v);
      @(negedge clk);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic wait_ready();
      logic [7:0] s;
      for (int t = 0; t < 80; t++) begin
         rd(3'd1, s);
         if (s[7]) break;
      end
   endtask

   // start via offset 2 with pulse widths wq[], then model the one-shots
   task automatic measure(input logic [3:0] en, input logic [1:0] rate, input logic ie);
      int maxw = 0;
      wr(3'd4, {5'b0, rate, ie});
      wr(3'd1, {4'b0000, en});
      for (int i = 0; i < 4; i++) if (en[i] && wq[i] > maxw) maxw = wq[i];
      @(negedge clk);
      axis_cmp = en;
      wr(3'd2, 8'h00);
      for (int j = 0; j <= maxw; j++) begin
         if (j > 0) begin
            @(posedge clk);
            #1;
         end
         for (int i = 0; i < 4; i++) if (j >= wq[i]) axis_cmp[i] = 1'b0;
      end
      axis_cmp = '0;
      for (int i = 0; i < 4; i++) if (en[i]) expv[i] = exp_count(wq[i], rate);
      wait_ready();
   endtask

   task automatic check_all(input logic [3:0] en, input string req);
      logic [7:0] lo, hi;
      for (int a = 0; a < 4; a++) begin
         wr(3'd1, {2'b00, 2'(a), en});
         rd(3'd2, lo);
         rd(3'd3, hi);
         check(req, {16'h0, hi, lo}, expv[a]);
      end
   endtask

   initial begin
      int seed;
      int rises;
      logic prev;
      logic [3:0] en;
      logic [1:0] rate;
      seed = 1234;
      void'($urandom(seed));
      for (int i = 0; i < 4; i++) expv[i] = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd(3'd1, d); check("R1 axcfg", d, 0);
      rd(3'd2, d); check("R1 val lo", d, 0);
      rd(3'd3, d); check("R1 val hi", d, 0);
      rd(3'd4, d); check("R1 hwcfg", d, 0);
      check("R1 irq", irq, 0);

      // R7 ready bit is read-only
      wr(3'd1, 8'h80);
      rd(3'd1, d); check("R7 ready not writable", d, 0);

      // R11 upper hwcfg bits and legacy enable
      wr(3'd4, 8'hFF);
      rd(3'd4, d); check("R11 hwcfg readback", d, 8'h0F);
      check("R11 legacy_en", legacy_en, 1);
      wr(3'd4, 8'h00);

      // R2/R3/R4 random patterns at full and 1/2 and 1/20 rates
      for (int it = 0; it < 8; it++) begin
         en = 4'($urandom_range(1, 15));
         rate = 2'($urandom_range(0, 2));
         for (int i = 0; i < 4; i++) wq[i] = $urandom_range(0, 300);
         measure(en, rate, 1'b1);
         rd(3'd1, d); check("R7 ready after run", d[7], 1);
         check("R8 irq with enable", irq, 1);
         check_all(en, "R2 R3 R4 counts");
      end

      // R5 directed divisors
      wq[0] = 7; wq[1] = 1000; wq[2] = 40; wq[3] = 0;
      measure(4'b0001, 2'd1, 1'b0);
      check("R8 irq masked", irq, 0);
      check_all(4'b0001, "R5 half rate");
      measure(4'b0010, 2'd3, 1'b0);
      check_all(4'b0010, "R5 slow rate");
      measure(4'b1100, 2'd2, 1'b0);
      check_all(4'b1100, "R5 twentieth rate");

      // R9 offset 0 gated by interrupt enable
      wq[0] = 50;
      measure(4'b0001, 2'd0, 1'b0);
      wr(3'd0, 8'h00);
      rd(3'd1, d); check("R9 no start when irq off", d[7], 1);
      check_all(4'b0001, "R9 value kept");
      wr(3'd4, 8'h01);
      axis_cmp = 4'b0000;
      wr(3'd0, 8'h00);
      rd(3'd1, d); check("R7 ready cleared by start", d[7], 0);
      wait_ready();
      expv[0] = 0;
      check_all(4'b0001, "R9 start with irq on");

      // R10 continuous mode
      axis_cmp = 4'b0000;
      wr(3'd4, 8'h01);
      wr(3'd1, 8'h41);
      wr(3'd2, 8'h00);
      rises = 0; prev = 1'b0;
      for (int t = 0; t < 120; t++) begin
         rd(3'd1, d);
         if (d[7] && !prev) rises++;
         prev = d[7];
      end
      check("R10 auto restarts", (rises >= 4) ? 1 : 0, 1);
      wr(3'd1, 8'h01);
      wait_ready();
      rises = 0;
      for (int t = 0; t < 40; t++) begin
         rd(3'd1, d);
         if (!d[7]) rises++;
      end
      check("R10 stops when cleared", rises, 0);

      // R6 saturation
      wq[0] = 70000;
      measure(4'b0001, 2'd0, 1'b0);
      check_all(4'b0001, "R6 saturate");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule